// File: doc/BRIEF.md
# Programmable Interval Timer with Register Port

This block divides the system clock down to a periodic event. A counter steps from 1 up to a programmed limit. On the step where it matches the limit it goes back to 1. That return is a rollover: it sets a sticky status bit, can drive an interrupt line, and is shown on a one-cycle `wrap_o` pulse.

In master operation, steps come from an internal power-of-two divider of the clock. In slave operation, steps come only from an external `sync_in` pulse. Every step is also sent out on `tick_o`. A master's `tick_o` can therefore feed the `sync_in` of any number of slave timers, and they all advance in lock step.

Software uses a small word-addressed register port. One strobe cycle starts an access, and an acknowledge follows on the next cycle. The block has no streaming data path. The bus uses a plain strobe/acknowledge pair with no back-pressure: every strobe is accepted and acknowledged exactly one cycle later.

Top module: `ivt_timer`

## Requirements
- R1: After reset, the control word reads 0x4000, the limit word reads 0x0000, the count word reads 0x0001, and `irq_o`, `tick_o` and `wrap_o` are low.
- R2: The control word is at address 0. Its bits are: bit 15 slave select, bits 11:8 divider select P, bit 2 rollover flag, bit 1 interrupt enable, bit 0 run. Bit 14 always reads 1, and all other bits read 0. Writing 0xFFFE reads back 0xCF02.
- R3: The limit word is at address 1. It reads back any 16-bit value written to it.
- R4: The count word is at address 2 and is read-only. A write to it leaves the reading unchanged.
- R5: In master mode with P=0, the counter steps on every clock, from 1 up to the limit, then returns to 1. `wrap_o` pulses for one cycle exactly every limit clocks. The first pulse comes limit clocks after the enabling write.
- R6: A rollover sets the flag (control bit 2). The flag stays set until a control write with bit 2 = 1 clears it. That write must also carry run = 1 for counting to continue.
- R7: `irq_o` is high exactly when both the flag and the interrupt enable are set.
- R8: In master mode the counter steps once every 2^P clocks, so the rollover period is limit × 2^P clocks.
- R9: With run = 0, the count word holds 1, the divider is cleared, and `tick_o` and `wrap_o` stay low.
- R10: In slave mode the counter steps only on clocks where `sync_in` is high, and it does not move while `sync_in` stays low.
- R11: A limit of 0 acts as 65536: the rollover period is 65536 steps.
- R12: `tick_o` gives exactly one one-cycle pulse per counter step, so there are `limit` pulses per rollover period.
- R13: `bus_ack` goes high on the cycle after each strobed cycle. Read data is valid on `bus_rdata` while `bus_ack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_stb | input | 1 | One-cycle access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word address: 0 control, 1 limit, 2 count |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid with `bus_ack` |
| bus_ack | output | 1 | Access acknowledge |
| sync_in | input | 1 | Step enable used in slave mode |
| irq_o | output | 1 | Interrupt request |
| tick_o | output | 1 | One-cycle pulse per counter step |
| wrap_o | output | 1 | One-cycle pulse per rollover |

## Verification
The assertions assume each access strobe lasts one cycle, so every strobe pulse is a separate access. They also assume `sync_in` is a clean synchronous level. The bus tasks in the bench raise `bus_stb` for exactly one clock edge per access. All inputs are driven on the falling edge. The bench changes the divider select and the limit only while run is 0, so rollover periods are measured from a known counter state.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  localparam int ADDR_W = 2;
  localparam int PSEL_W = 4;

  localparam logic [ADDR_W-1:0] OFF_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] OFF_LIM  = 2'd1;
  localparam logic [ADDR_W-1:0] OFF_CNT  = 2'd2;

  // control word bit positions (software-visible)
  localparam int B_SLAVE = 15;
  localparam int B_ONE   = 14;
  localparam int B_PS_LO = 8;
  localparam int B_FLAG  = 2;
  localparam int B_IEN   = 1;
  localparam int B_RUN   = 0;

  typedef struct packed {
    logic              slave;
    logic [PSEL_W-1:0] psel;
    logic              flag;
    logic              ien;
    logic              run;
  } ctrl_t;
endpackage

// File: rtl/ivt_prescale.sv
module ivt_prescale
  import ivt_pkg::*;
#(
  parameter int SEL_W = PSEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             slave,
  input  logic             sync_in,
  input  logic [SEL_W-1:0] psel,
  output logic             adv
);
  localparam int DIV_W = (1 << SEL_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;

  // mask has the P lowest bits set
  for (genvar i = 0; i < DIV_W; i++) begin : g_mask
    assign mask[i] = (SEL_W'(i) < psel);
  end

  assign adv = run & (slave ? sync_in : ((div_q & mask) == mask));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   div_q <= '0;
    else if (!run || slave || adv) div_q <= '0;
    else                          div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/ivt_counter.sv
module ivt_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          adv,
  input  logic [CW-1:0] lim,
  output logic [CW-1:0] count,
  output logic          roll,
  output logic          tick_o,
  output logic          wrap_o
);
  // a limit of 0 matches the wrapped value 0, which stands for 2^CW
  assign roll = adv & (count == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count  <= CW'(1);
      tick_o <= 1'b0;
      wrap_o <= 1'b0;
    end else begin
      tick_o <= adv;
      wrap_o <= roll;
      if (!run || roll) count <= CW'(1);
      else if (adv)     count <= count + 1'b1;
    end
  end

  p_reload_on_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |-> count == CW'(1));

  p_idle_when_stopped_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (count == CW'(1) && !tick_o && !wrap_o));

  p_one_step_per_tick_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && !wrap_o) |-> count == $past(count) + CW'(1));
endmodule

// File: rtl/ivt_regs.sv
module ivt_regs
  import ivt_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic              ack,
  input  logic              roll,
  input  logic [DW-1:0]     count,
  output ctrl_t             ctrl,
  output logic [DW-1:0]     lim
);
  logic          wr_ctrl, wr_lim, clr_flag;
  logic [DW-1:0] rd_mux, ctrl_view;

  assign wr_ctrl  = stb & we & (addr == OFF_CTRL);
  assign wr_lim   = stb & we & (addr == OFF_LIM);
  assign clr_flag = wr_ctrl & wdata[B_FLAG];

  always_comb begin
    ctrl_view                        = '0;
    ctrl_view[B_SLAVE]               = ctrl.slave;
    ctrl_view[B_ONE]                 = 1'b1;
    ctrl_view[B_PS_LO +: PSEL_W]     = ctrl.psel;
    ctrl_view[B_FLAG]                = ctrl.flag;
    ctrl_view[B_IEN]                 = ctrl.ien;
    ctrl_view[B_RUN]                 = ctrl.run;
    unique case (addr)
      OFF_CTRL: rd_mux = ctrl_view;
      OFF_LIM:  rd_mux = lim;
      OFF_CNT:  rd_mux = count;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl  <= '0;
      lim   <= '0;
      ack   <= 1'b0;
      rdata <= '0;
    end else begin
      ack       <= stb;
      ctrl.flag <= roll | (ctrl.flag & ~clr_flag);
      if (wr_ctrl) begin
        ctrl.slave <= wdata[B_SLAVE];
        ctrl.psel  <= wdata[B_PS_LO +: PSEL_W];
        ctrl.ien   <= wdata[B_IEN];
        ctrl.run   <= wdata[B_RUN];
      end
      if (wr_lim)       lim   <= wdata;
      if (stb && !we)   rdata <= rd_mux;
    end
  end

  p_ack_after_stb_r13: assert property (@(posedge clk) disable iff (!rst_n)
    stb |=> ack);

  p_no_stray_ack_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !stb |=> !ack);

  p_flag_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    roll |=> ctrl.flag);

  p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.flag && !clr_flag) |=> ctrl.flag);
endmodule

// File: rtl/ivt_timer.sv
module ivt_timer
  import ivt_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_stb,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              bus_ack,
  input  logic              sync_in,
  output logic              irq_o,
  output logic              tick_o,
  output logic              wrap_o
);
  ctrl_t         ctrl;
  logic [DW-1:0] lim, count;
  logic          adv, roll;

  ivt_regs #(.DW(DW)) regs_i (
    .clk(clk), .rst_n(rst_n), .stb(bus_stb), .we(bus_we), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata), .ack(bus_ack), .roll(roll),
    .count(count), .ctrl(ctrl), .lim(lim)
  );

  ivt_prescale #(.SEL_W(PSEL_W)) pre_i (
    .clk(clk), .rst_n(rst_n), .run(ctrl.run), .slave(ctrl.slave),
    .sync_in(sync_in), .psel(ctrl.psel), .adv(adv)
  );

  ivt_counter #(.CW(DW)) cnt_i (
    .clk(clk), .rst_n(rst_n), .run(ctrl.run), .adv(adv), .lim(lim),
    .count(count), .roll(roll), .tick_o(tick_o), .wrap_o(wrap_o)
  );

  assign irq_o = ctrl.flag & ctrl.ien;

  p_slave_waits_sync_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.slave && !sync_in) |=> !tick_o);
endmodule

// File: tb/ivt_timer_tb_top.sv
module ivt_timer_tb_top;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_stb = 1'b0, bus_we = 1'b0, sync_in = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        bus_ack, irq_o, tick_o, wrap_o;
  int          n_chk = 0, n_err = 0;

  always #(CLK_NS/2) clk = ~clk;

  ivt_timer dut_i (
    .clk(clk), .rst_n(rst_n), .bus_stb(bus_stb), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ack(bus_ack), .sync_in(sync_in), .irq_o(irq_o), .tick_o(tick_o),
    .wrap_o(wrap_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [1:0] a, logic [15:0] d);
    @(negedge clk);
    bus_stb = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_stb = 1'b0; bus_we = 1'b0;
    chk("R13 write ack", bus_ack, 1);
  endtask

  task automatic bus_read(logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_stb = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    bus_stb = 1'b0;
    chk("R13 read ack", bus_ack, 1);
    d = bus_rdata;
  endtask

  // counts negedges until wrap_o is seen, and tick pulses over that window
  task automatic wait_wrap(output int k, output int ticks);
    k = 0; ticks = 0;
    do begin
      @(negedge clk);
      k++;
      if (tick_o) ticks++;
    end while (!wrap_o && k < 70000);
  endtask

  task automatic t_reset;
    logic [15:0] d;
    chk("R1 irq", irq_o, 0);
    chk("R1 tick", tick_o, 0);
    chk("R1 wrap", wrap_o, 0);
    bus_read(2'd0, d); chk("R1 ctrl", d, 16'h4000);
    bus_read(2'd1, d); chk("R1 limit", d, 16'h0000);
    bus_read(2'd2, d); chk("R1 count", d, 16'h0001);
  endtask

  task automatic t_regs;
    logic [15:0] d;
    bus_write(2'd0, 16'hFFFE); bus_read(2'd0, d); chk("R2 ctrl FFFE", d, 16'hCF02);
    bus_write(2'd0, 16'h0000); bus_read(2'd0, d); chk("R2 ctrl 0", d, 16'h4000);
    bus_write(2'd1, 16'h5555); bus_read(2'd1, d); chk("R3 lim 5555", d, 16'h5555);
    bus_write(2'd1, 16'hAAAA); bus_read(2'd1, d); chk("R3 lim AAAA", d, 16'hAAAA);
    bus_write(2'd2, 16'hFFFE); bus_read(2'd2, d); chk("R4 count ro", d, 16'h0001);
  endtask

  task automatic t_master(logic [3:0] p, logic [15:0] lim, string req);
    int k, tk;
    int unsigned per;
    per = (lim == 0 ? 65536 : int'(lim)) << p;
    bus_write(2'd0, 16'h0000);
    bus_write(2'd1, lim);
    bus_write(2'd0, {4'h0, p, 8'h01});
    wait_wrap(k, tk);
    chk({req, " first period"}, k, per);
    chk("R12 ticks per period", tk, (lim == 0 ? 65536 : int'(lim)));
    wait_wrap(k, tk);
    chk({req, " second period"}, k, per);
    @(negedge clk);
    chk("R5 wrap one cycle", wrap_o, 0);
    bus_write(2'd0, 16'h0000);
  endtask

  task automatic t_flag;
    logic [15:0] d;
    int k, tk;
    bus_write(2'd1, 16'd40);
    bus_write(2'd0, 16'h0001);          // no interrupt enable
    wait_wrap(k, tk);
    chk("R7 irq off while ien=0", irq_o, 0);
    bus_write(2'd0, 16'h0007);          // clear flag, ien, run
    wait_wrap(k, tk);
    chk("R7 irq on", irq_o, 1);
    repeat (10) @(negedge clk);
    bus_read(2'd0, d); chk("R6 flag sticky", d, 16'h4007);
    bus_write(2'd0, 16'h0007);
    bus_read(2'd0, d); chk("R6 flag cleared", d, 16'h4003);
    chk("R7 irq cleared", irq_o, 0);
  endtask

  task automatic t_disable;
    logic [15:0] d;
    int tk = 0;
    bus_write(2'd0, 16'h0000);
    bus_read(2'd2, d); chk("R9 count reload", d, 16'h0001);
    repeat (20) begin @(negedge clk); if (tick_o || wrap_o) tk++; end
    chk("R9 no ticks while off", tk, 0);
    bus_read(2'd2, d); chk("R9 count held", d, 16'h0001);
  endtask

  task automatic pulse_sync;
    @(negedge clk); sync_in = 1'b1;
    @(negedge clk); sync_in = 1'b0;
  endtask

  task automatic t_slave;
    logic [15:0] d;
    bus_write(2'd1, 16'd4);
    bus_write(2'd0, 16'h8001);
    repeat (12) @(negedge clk);
    bus_read(2'd2, d); chk("R10 no sync no step", d, 16'h0001);
    repeat (3) pulse_sync();
    repeat (10) @(negedge clk);
    bus_read(2'd2, d); chk("R10 three steps", d, 16'h0004);
    pulse_sync();
    chk("R10 wrap on fourth sync", wrap_o, 1);
    bus_read(2'd2, d); chk("R10 reload", d, 16'h0001);
    bus_write(2'd0, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_master(4'd0, 16'd5, "R5");
    t_master(4'd2, 16'd3, "R8");
    t_master(4'd3, 16'd7, "R8");
    t_flag();
    t_disable();
    t_slave();
    t_master(4'd0, 16'd0, "R11");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule